// File: doc/BRIEF.md
# Per-Line Write-Intensity Tracker

This block sits beside the tag array of a hybrid last-level cache whose data storage is split into a fast-to-write region and a dense but slow-to-write region. For every cache line it keeps a small saturating counter. The counter rises on write hits and falls on read hits. It also keeps a dirty flag and the write-intensity bit the line arrived with. When the cache evicts a line, the tracker turns the counter into a one-bit write-intensity verdict. It then decides whether the line has to go back to memory.

A dirty line always goes back, carrying the fresh verdict. A clean line goes back only when its learned verdict no longer matches the bit it was installed with. This keeps the verdict stored alongside the data in memory up to date. A configuration input can switch the clean-line writeback off completely. The tag match, the replacement choice and the data arrays are handled elsewhere. The tracker only receives line indices and event strobes.

The threshold is a runtime input. The intended setting is 3.

Top module: `wi_line_tracker`

## Requirements
- R1: After reset, every line has counter 0, dirty flag 0 and install bit 0, and `evict_valid` is 0.
- R2: An install sets the line's counter to 7 when `install_wi` is 1 and to 0 otherwise. It clears the dirty flag and stores `install_wi` as the line's install bit. An install takes priority over a read or write hit to the same line in the same cycle.
- R3: A write hit adds one to the line's counter, holding at 7, and sets its dirty flag.
- R4: A read hit subtracts one from the line's counter, holding at 0, and leaves the dirty flag unchanged.
- R5: When a read hit and a write hit name the same line in one cycle, only the write hit takes effect. Hits on different lines in one cycle both take effect.
- R6: `evict_wi` is 1 when the evicted line's counter is strictly greater than `cfg_threshold`, and 0 when it is equal or smaller.
- R7: An evicted dirty line gives `evict_dirty` = 1 and `evict_wb` = 1.
- R8: With `cfg_clean_wb_en` = 1, an evicted clean line gives `evict_wb` = 1 exactly when `evict_wi` differs from the line's install bit.
- R9: With `cfg_clean_wb_en` = 0, an evicted clean line never gives `evict_wb` = 1.
- R10: Eviction results appear one cycle after `evict_req`, with `evict_valid` = 1 for that one cycle. They reflect the line's state before any update made in the request cycle. Otherwise `evict_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clean_wb_en | input | 1 | Enables writeback of clean lines whose verdict changed |
| cfg_threshold | input | 3 | Write-intensity threshold |
| install_en | input | 1 | Install strobe |
| install_idx | input | IDX_W | Line being installed |
| install_wi | input | 1 | Incoming write-intensity bit |
| rd_hit | input | 1 | Read hit strobe |
| rd_idx | input | IDX_W | Line hit by the read |
| wr_hit | input | 1 | Write hit strobe |
| wr_idx | input | IDX_W | Line hit by the write |
| evict_req | input | 1 | Eviction request |
| evict_idx | input | IDX_W | Line being evicted |
| evict_valid | output | 1 | Eviction results valid |
| evict_wi | output | 1 | Computed write-intensity verdict |
| evict_dirty | output | 1 | Evicted line was dirty |
| evict_wb | output | 1 | Evicted line must be written back |

## Verification
The bench builds the tracker with 8 lines and the 3-bit counter. This keeps the full counter range, both saturation limits and several same-cycle collisions between install, read, write and evict on one line within a short run. During the run the threshold is swept over every value from 0 to 7, so the verdict boundary is checked at each counter value, including the equal case. The clean-writeback enable is toggled, so that both clean-line outcomes are reached with and without a changed verdict.

// File: rtl/wi_pkg.sv
package wi_pkg;
  parameter int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t sat_up(input cnt_t c);
    return (c == CNT_MAX) ? c : c + cnt_t'(1);
  endfunction

  function automatic cnt_t sat_down(input cnt_t c);
    return (c == '0) ? c : c - cnt_t'(1);
  endfunction

  function automatic logic wi_verdict(input cnt_t c, input cnt_t thr);
    return c > thr;
  endfunction
endpackage

// File: rtl/wi_line_entry.sv
module wi_line_entry
  import wi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inst,
  input  logic inst_wi,
  input  logic rd,
  input  logic wr,
  output cnt_t cnt,
  output logic dirty,
  output logic base_wi
);
  // named events for the assertions
  logic ev_write, ev_read;
  assign ev_write = wr && !inst;
  assign ev_read  = rd && !wr && !inst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      dirty   <= 1'b0;
      base_wi <= 1'b0;
    end else if (inst) begin
      cnt     <= inst_wi ? CNT_MAX : '0;
      dirty   <= 1'b0;
      base_wi <= inst_wi;
    end else if (ev_write) begin
      cnt   <= sat_up(cnt);
      dirty <= 1'b1;
    end else if (ev_read) begin
      cnt <= sat_down(cnt);
    end
  end

  p_install_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inst |=> (cnt == (base_wi ? CNT_MAX : '0)) && !dirty);
  p_wr_sets_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> dirty);
  p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write && cnt == CNT_MAX |=> cnt == CNT_MAX);
  p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read && cnt == '0 |=> cnt == '0);
  p_read_keeps_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> $stable(dirty));
  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd && wr && !inst && cnt != CNT_MAX |=> cnt != '0);
endmodule

// File: rtl/wi_evict_judge.sv
module wi_evict_judge
  import wi_pkg::*;
(
  input  cnt_t cnt,
  input  cnt_t thr,
  input  logic dirty,
  input  logic base_wi,
  input  logic clean_en,
  output logic wi,
  output logic wb
);
  logic changed;
  always_comb begin
    wi      = wi_verdict(cnt, thr);
    changed = wi ^ base_wi;
    wb      = dirty || (clean_en && changed);
  end
endmodule

// File: rtl/wi_line_tracker.sv
module wi_line_tracker
  import wi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clean_wb_en,
  input  logic [CNT_W-1:0] cfg_threshold,
  input  logic             install_en,
  input  logic [IDX_W-1:0] install_idx,
  input  logic             install_wi,
  input  logic             rd_hit,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             evict_req,
  input  logic [IDX_W-1:0] evict_idx,
  output logic             evict_valid,
  output logic             evict_wi,
  output logic             evict_dirty,
  output logic             evict_wb
);
  cnt_t cnt_a   [LINES];
  logic dirty_a [LINES];
  logic base_a  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wi_line_entry u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .inst    (install_en && install_idx == IDX_W'(g)),
      .inst_wi (install_wi),
      .rd      (rd_hit && rd_idx == IDX_W'(g)),
      .wr      (wr_hit && wr_idx == IDX_W'(g)),
      .cnt     (cnt_a[g]),
      .dirty   (dirty_a[g]),
      .base_wi (base_a[g])
    );
  end

  cnt_t sel_cnt;
  logic sel_dirty, sel_base, nxt_wi, nxt_wb;
  always_comb begin
    sel_cnt   = cnt_a[evict_idx];
    sel_dirty = dirty_a[evict_idx];
    sel_base  = base_a[evict_idx];
  end

  wi_evict_judge u_judge (
    .cnt      (sel_cnt),
    .thr      (cfg_threshold),
    .dirty    (sel_dirty),
    .base_wi  (sel_base),
    .clean_en (cfg_clean_wb_en),
    .wi       (nxt_wi),
    .wb       (nxt_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evict_valid <= 1'b0;
      evict_wi    <= 1'b0;
      evict_dirty <= 1'b0;
      evict_wb    <= 1'b0;
    end else begin
      evict_valid <= evict_req;
      evict_wi    <= evict_req && nxt_wi;
      evict_dirty <= evict_req && sel_dirty;
      evict_wb    <= evict_req && nxt_wb;
    end
  end

  p_dirty_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && evict_dirty |-> evict_wb);
  p_clean_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_clean_wb_en) && evict_valid && !evict_dirty |-> !evict_wb);
  p_ev_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req |=> evict_valid);
  p_ev_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_req |=> !evict_valid && !evict_wb);
  p_verdict_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req && cfg_threshold == CNT_MAX |=> !evict_wi);
endmodule

// File: tb/wi_line_tracker_test.sv
module wi_line_tracker_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_clean_wb_en;
  logic [2:0] cfg_threshold;
  logic install_en, install_wi, rd_hit, wr_hit, evict_req;
  logic [IW-1:0] install_idx, rd_idx, wr_idx, evict_idx;
  logic evict_valid, evict_wi, evict_dirty, evict_wb;

  always #5 clk = ~clk;

  wi_line_tracker #(.LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_clean_wb_en(cfg_clean_wb_en),
    .cfg_threshold(cfg_threshold), .install_en(install_en),
    .install_idx(install_idx), .install_wi(install_wi),
    .rd_hit(rd_hit), .rd_idx(rd_idx), .wr_hit(wr_hit), .wr_idx(wr_idx),
    .evict_req(evict_req), .evict_idx(evict_idx),
    .evict_valid(evict_valid), .evict_wi(evict_wi),
    .evict_dirty(evict_dirty), .evict_wb(evict_wb));

  int n_tests = 0;
  int n_fail = 0;
  int m_cnt [N];
  bit m_dirty [N];
  bit m_base [N];
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, predict, compare at the following negedge
  task automatic step(input bit ie, input int ii, input bit iw,
                      input bit re, input int ri, input bit we, input int wi,
                      input bit ee, input int ei, input string tag);
    bit e_wi, e_dirty, e_wb;
    install_en = ie; install_idx = IW'(ii); install_wi = iw;
    rd_hit = re; rd_idx = IW'(ri); wr_hit = we; wr_idx = IW'(wi);
    evict_req = ee; evict_idx = IW'(ei);
    e_wi = m_cnt[ei] > int'(cfg_threshold);
    e_dirty = m_dirty[ei];
    e_wb = e_dirty || (cfg_clean_wb_en && (e_wi != m_base[ei]));
    for (int k = 0; k < N; k++) begin
      if (ie && ii == k) begin
        m_cnt[k] = iw ? 7 : 0; m_dirty[k] = 0; m_base[k] = iw;
      end else if (we && wi == k) begin
        if (m_cnt[k] < 7) m_cnt[k]++;
        m_dirty[k] = 1;
      end else if (re && ri == k) begin
        if (m_cnt[k] > 0) m_cnt[k]--;
      end
    end
    @(negedge clk);
    check("R10 valid", int'(evict_valid), int'(ee));
    if (ee) begin
      check({"R6 ", tag}, int'(evict_wi), int'(e_wi));
      check({"R7 ", tag}, int'(evict_dirty), int'(e_dirty));
      if (e_dirty) check({"R7 ", tag}, int'(evict_wb), int'(e_wb));
      else if (!cfg_clean_wb_en) check({"R9 ", tag}, int'(evict_wb), int'(e_wb));
      else check({"R8 ", tag}, int'(evict_wb), int'(e_wb));
    end else begin
      check("R10 idle", int'(evict_wb), 0);
    end
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0,"idle"); endtask
  task automatic inst(input int i, input bit w); step(1,i,w,0,0,0,0,0,0,"inst"); endtask
  task automatic rd(input int i); step(0,0,0,1,i,0,0,0,0,"rd"); endtask
  task automatic wr(input int i); step(0,0,0,0,0,1,i,0,0,"wr"); endtask
  task automatic ev(input int i, input string t); step(0,0,0,0,0,0,0,1,i,t); endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_cnt[k] = 0; m_dirty[k] = 0; m_base[k] = 0; end
    rst_n = 0; cfg_clean_wb_en = 1; cfg_threshold = 3;
    install_en = 0; install_idx = 0; install_wi = 0; rd_hit = 0; rd_idx = 0;
    wr_hit = 0; wr_idx = 0; evict_req = 0; evict_idx = 0;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", int'(evict_valid), 0);
    rst_n = 1;
    // R1: fresh lines read back clean, counter 0
    ev(0, "R1 reset line");
    cfg_threshold = 0; ev(7, "R1 counter zero");
    // R2: install high, counter 7; sweep threshold 6 and 7
    cfg_threshold = 3; inst(1, 1);
    cfg_threshold = 6; ev(1, "R2 high install");
    cfg_threshold = 7; ev(1, "R2 equal max R8 changed");
    // R3 / R6: four writes on low install
    cfg_threshold = 3; inst(2, 0);
    repeat (4) wr(2);
    ev(2, "R3 count4 thr3");
    cfg_threshold = 4; ev(2, "R6 equal is low");
    // R3 saturation, R4 floor
    repeat (10) wr(3);
    cfg_threshold = 6; ev(3, "R3 saturate");
    repeat (10) rd(3);
    cfg_threshold = 0; ev(3, "R4 floor dirty kept");
    // R5: same-line read and write
    cfg_threshold = 3; inst(4, 0);
    repeat (4) step(0,0,0,1,4,1,4,0,0,"R5");
    ev(4, "R5 write wins");
    // R5: different lines both act
    inst(6, 1); inst(5, 0);
    step(0,0,0,1,6,1,5,0,0,"R5 split");
    cfg_threshold = 5; ev(6, "R5 read applied");
    cfg_threshold = 0; ev(5, "R5 write applied");
    // R9: clean writeback disabled
    cfg_clean_wb_en = 0; cfg_threshold = 3; inst(0, 1);
    repeat (7) rd(0);
    ev(0, "R9 changed but off");
    cfg_clean_wb_en = 1; ev(0, "R8 changed on");
    // R10: evict sees pre-update state; R2: install beats write
    inst(7, 0);
    step(0,0,0,0,0,1,7,1,7,"R10 pre-update");
    ev(7, "R10 after write");
    step(1,7,1,0,0,1,7,0,0,"R2 install wins");
    cfg_threshold = 6; ev(7, "R2 install wins check");
    // threshold sweep on one line
    inst(1, 0);
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 8; t++) begin cfg_threshold = 3'(t); ev(1, "R6 sweep"); end
      wr(1);
    end
    // mixed random traffic
    for (int j = 0; j < 400; j++) begin
      cfg_threshold = 3'($urandom_range(0, 7));
      cfg_clean_wb_en = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0,3) == 0), $urandom_range(0,N-1), 1'($urandom_range(0,1)),
           1'($urandom_range(0,1)), $urandom_range(0,N-1),
           1'($urandom_range(0,1)), $urandom_range(0,N-1),
           1'($urandom_range(0,1)), $urandom_range(0,N-1), "mixed");
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule